// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

This block is the control engine of a queued SPI master. It owns a small queue of entries. Each entry holds a command word, a transmit word and a receive word. Once software sets the enable bit, the sequencer starts at a programmed start index. For each entry it hands the transmit word and the length code to a separate serial shift engine. When the shift engine reports completion, the sequencer writes the received word back into the same entry. It then records which entry finished and moves on to the next one.

Each command word carries a chip-select pattern and a continue bit. The continue bit decides whether the chip selects stay asserted across the boundary to the next entry, or fall back to a programmable idle pattern. When the entry at the last-pointer index completes, a sticky end flag is raised and an interrupt may be requested. After that the sequencer either stops or starts again from entry 0.

Software reaches every register and all three queue arrays through a simple word-wide register port. Writes are strobed. Reads are combinational.

The transfer hand-off uses valid/ready:
- `xfer_valid` rises when an entry is launched.
- `xfer_valid` and its fields stay constant until the shift engine raises `xfer_ready` in a clock cycle where `xfer_valid` is high.
- The shift engine may hold `xfer_ready` low for any number of cycles. That back-pressure only postpones the launch.

The result path has no back-pressure. A one-cycle `done_valid` is always accepted while a transfer is outstanding, and is ignored otherwise.

Top module: `spi_queue_seq`

## Requirements
- R1: `cpu_addr[5:4]` selects a region and `cpu_addr[3:0]` selects an index or register offset. The regions are:
  - 0: registers.
  - 1: transmit words.
  - 2: received words, read-only.
  - 3: command words.

  The registers are:
  - Offset 0: control. Bit 0 is enable, bit 1 is wraparound, bit 2 is interrupt enable.
  - Offset 1: start pointer.
  - Offset 2: last pointer.
  - Offset 3: finished pointer, read-only.
  - Offset 4: status. Bit 0 is the end flag.
  - Offset 5: idle chip-select pattern.

  A command word holds the chip-select pattern in bits 3:0, the length code in bits 7:4 (presented on `xfer_len`) and the continue bit in bit 8.
- R2: When enable goes from 0 to 1 while the sequencer is idle, the first transfer sends the transmit word of the entry at the start pointer. Its result is stored in the received word of that same entry.
- R3: Each accepted result updates three things:
  - the received word of the finished entry;
  - the finished pointer, which takes that entry's index;
  - the working index, which advances to the next entry.
- R4: A write to the start pointer while a run is active makes the next launched entry the written index, in place of the incremented one.
- R5: An entry whose continue bit is set, followed by an entry with the same chip-select pattern, keeps `cs_out` at that pattern through both transfers and the boundary between them. `cs_out` does not take the idle value at any point in that span.
- R6: An entry whose continue bit is set, followed by an entry with a different pattern, holds its own pattern for the whole of its transfer. `cs_out` switches to the new pattern no later than the cycle in which the next transfer is offered.
- R7: After an entry whose continue bit is clear, `cs_out` shows the programmed idle pattern for at least one cycle before the next transfer is offered.
- R8: The end flag is set whenever the finished index equals the last pointer, with or without wraparound.
- R9: Without wraparound, finishing the last entry clears the enable bit. The sequencer then issues no further transfers and `cs_out` returns to the idle pattern.
- R10: With wraparound, the entry after the last one is entry 0, and the run continues until enable is cleared. Clearing enable stops the run after the current transfer.
- R11: The end flag clears only on this sequence: a status read that sees the flag set, followed by a status write with bit 0 equal to 0. A zero write with no such read leaves the flag set. Any status write cancels a pending read.
- R12: `irq` is high while the end flag is set, provided the interrupt enable was on when the flag was last set. Clearing the interrupt enable does not remove a request already raised. It only masks requests from later settings of the flag.
- R13: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_tx` and `xfer_len` stay unchanged.
- R14: Reset leaves the following state:
  - control, pointers and flag at 0;
  - idle pattern all ones, and `cs_out` all ones;
  - `xfer_valid` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register or queue write strobe |
| cpu_rd | input | 1 | Read strobe; only matters for the status register |
| cpu_addr | input | PTR_W+2 | Region and index or offset |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, combinational from `cpu_addr` |
| xfer_valid | output | 1 | A launched transfer is offered to the shift engine |
| xfer_ready | input | 1 | The shift engine takes the offered transfer |
| xfer_tx | output | DATA_W | Transmit word of the offered transfer |
| xfer_len | output | LEN_W | Length code from the command word |
| done_valid | input | 1 | One-cycle pulse marking the end of the outstanding transfer |
| done_rx | input | DATA_W | Received word, qualified by `done_valid` |
| cs_out | output | CS_W | Peripheral chip-select pins |
| irq | output | 1 | End-of-queue interrupt request |

## Verification
The bench builds the block with its default parameters:
- 16-bit words;
- a 16-entry queue addressed by 4-bit pointers;
- four chip-select lines.

With these values the full address map fits in six address bits. A last pointer of 15 makes the natural pointer rollover and the wrap-to-zero rule meet in the same entry. The bench's own shift-engine model adds a variable ready delay, which exercises the hold rule on the offered transfer.

// File: rtl/spi_queue_pkg.sv
package spi_queue_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_BUSY,
    SQ_GAP
  } sq_state_e;

  localparam logic [1:0] RGN_REG = 2'd0;
  localparam logic [1:0] RGN_TX  = 2'd1;
  localparam logic [1:0] RGN_RX  = 2'd2;
  localparam logic [1:0] RGN_CMD = 2'd3;

  localparam int OFF_CTRL  = 0;
  localparam int OFF_NEWP  = 1;
  localparam int OFF_ENDP  = 2;
  localparam int OFF_DONEP = 3;
  localparam int OFF_STAT  = 4;
  localparam int OFF_IDLE  = 5;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_WRAP  = 1;
  localparam int CTRL_IRQEN = 2;

endpackage

// File: rtl/spi_queue_ram.sv
module spi_queue_ram #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4,
  parameter int CMD_W  = 9
) (
  input  logic              clk,
  input  logic              tx_we,
  input  logic              cmd_we,
  input  logic [PTR_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_tx,
  output logic [DATA_W-1:0] cpu_rx,
  output logic [CMD_W-1:0]  cpu_cmd,
  input  logic [PTR_W-1:0]  seq_idx,
  output logic [DATA_W-1:0] seq_tx,
  output logic [CMD_W-1:0]  seq_cmd,
  input  logic              rx_we,
  input  logic [PTR_W-1:0]  rx_idx,
  input  logic [DATA_W-1:0] rx_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] tx_mem  [DEPTH];
  logic [DATA_W-1:0] rx_mem  [DEPTH];
  logic [CMD_W-1:0]  cmd_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (tx_we)  tx_mem[cpu_idx]  <= cpu_wdata;
    if (cmd_we) cmd_mem[cpu_idx] <= cpu_wdata[CMD_W-1:0];
    if (rx_we)  rx_mem[rx_idx]   <= rx_data;
  end

  assign cpu_tx  = tx_mem[cpu_idx];
  assign cpu_rx  = rx_mem[cpu_idx];
  assign cpu_cmd = cmd_mem[cpu_idx];
  assign seq_tx  = tx_mem[seq_idx];
  assign seq_cmd = cmd_mem[seq_idx];

endmodule

// File: rtl/spi_queue_regs.sv
module spi_queue_regs
  import spi_queue_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4,
  parameter int CS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [PTR_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_set,
  input  logic              en_clr,
  input  logic [PTR_W-1:0]  done_ptr,
  output logic              en,
  output logic              wrap,
  output logic [PTR_W-1:0]  new_ptr,
  output logic              newp_wr,
  output logic [PTR_W-1:0]  end_ptr,
  output logic [CS_W-1:0]   idle_cs,
  output logic              flag,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  logic irq_en, irq_arm, clr_arm;
  logic hit_ctrl, hit_newp, hit_endp, hit_stat, hit_idle;

  assign hit_ctrl = (off == PTR_W'(OFF_CTRL));
  assign hit_newp = (off == PTR_W'(OFF_NEWP));
  assign hit_endp = (off == PTR_W'(OFF_ENDP));
  assign hit_stat = (off == PTR_W'(OFF_STAT));
  assign hit_idle = (off == PTR_W'(OFF_IDLE));
  assign newp_wr  = wr && hit_newp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      wrap    <= 1'b0;
      irq_en  <= 1'b0;
      new_ptr <= '0;
      end_ptr <= '0;
      idle_cs <= '1;
      flag    <= 1'b0;
      irq_arm <= 1'b0;
      clr_arm <= 1'b0;
    end else begin
      if (en_clr) en <= 1'b0;
      if (wr && hit_ctrl) begin
        en     <= wdata[CTRL_EN];
        wrap   <= wdata[CTRL_WRAP];
        irq_en <= wdata[CTRL_IRQEN];
      end
      if (newp_wr)            new_ptr <= wdata[PTR_W-1:0];
      if (wr && hit_endp)     end_ptr <= wdata[PTR_W-1:0];
      if (wr && hit_idle)     idle_cs <= wdata[CS_W-1:0];
      if (rd && hit_stat && flag) clr_arm <= 1'b1;
      if (wr && hit_stat) begin
        clr_arm <= 1'b0;
        if (clr_arm && !wdata[0]) flag <= 1'b0;
      end
      if (flag_set) begin
        flag    <= 1'b1;
        irq_arm <= irq_en;
      end
    end
  end

  assign irq = flag && irq_arm;

  always_comb begin
    rdata = '0;
    unique case (1'b1)
      hit_ctrl: rdata[2:0]       = {irq_en, wrap, en};
      hit_newp: rdata[PTR_W-1:0] = new_ptr;
      hit_endp: rdata[PTR_W-1:0] = end_ptr;
      (off == PTR_W'(OFF_DONEP)): rdata[PTR_W-1:0] = done_ptr;
      hit_stat: rdata[0]         = flag;
      hit_idle: rdata[CS_W-1:0]  = idle_cs;
      default:  rdata = '0;
    endcase
  end

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr && hit_stat && !wdata[0]));

  p_irq_raise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set && irq_en |=> irq);

endmodule

// File: rtl/spi_queue_fsm.sv
module spi_queue_fsm
  import spi_queue_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4,
  parameter int CS_W   = 4,
  parameter int LEN_W  = 4,
  localparam int CMD_W = CS_W + LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wrap,
  input  logic [PTR_W-1:0]  new_ptr,
  input  logic              newp_wr,
  input  logic [PTR_W-1:0]  end_ptr,
  input  logic [CS_W-1:0]   idle_cs,
  output logic [PTR_W-1:0]  seq_idx,
  input  logic [DATA_W-1:0] seq_tx,
  input  logic [CMD_W-1:0]  seq_cmd,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [DATA_W-1:0] xfer_tx,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              done_valid,
  output logic              rx_we,
  output logic [PTR_W-1:0]  rx_idx,
  output logic [PTR_W-1:0]  done_ptr,
  output logic              flag_set,
  output logic              en_clr,
  output logic [CS_W-1:0]   cs_out
);
  sq_state_e        state_q;
  logic [PTR_W-1:0] wptr_q, nxt_ptr, pick;
  logic             pend_q, cont_q, last, fin, halt, launch;
  logic [CS_W-1:0]  cs_q;

  always_comb begin
    last     = (wptr_q == end_ptr);
    nxt_ptr  = last ? '0 : wptr_q + 1'b1;
    pick     = pend_q ? new_ptr : ((state_q == SQ_BUSY) ? nxt_ptr : wptr_q);
    seq_idx  = (state_q == SQ_IDLE) ? new_ptr : pick;
    fin      = (state_q == SQ_BUSY) && done_valid;
    flag_set = fin && last;
    en_clr   = fin && last && !wrap;
    halt     = fin && ((last && !wrap) || !en);
    launch   = (((state_q == SQ_IDLE) || (state_q == SQ_GAP)) && en)
            || (fin && !halt && cont_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      wptr_q   <= '0;
      pend_q   <= 1'b0;
      cont_q   <= 1'b0;
      cs_q     <= '1;
      xfer_tx  <= '0;
      xfer_len <= '0;
      done_ptr <= '0;
    end else begin
      if (newp_wr)     pend_q <= 1'b1;
      else if (launch) pend_q <= 1'b0;
      if (fin) done_ptr <= wptr_q;
      if (launch) begin
        wptr_q   <= seq_idx;
        xfer_tx  <= seq_tx;
        xfer_len <= seq_cmd[CS_W +: LEN_W];
        cont_q   <= seq_cmd[CMD_W-1];
        cs_q     <= seq_cmd[CS_W-1:0];
        state_q  <= SQ_ISSUE;
      end else begin
        unique case (state_q)
          SQ_IDLE:  cs_q <= idle_cs;
          SQ_ISSUE: if (xfer_ready) state_q <= SQ_BUSY;
          SQ_BUSY: if (fin) begin
            cs_q    <= idle_cs;
            wptr_q  <= nxt_ptr;
            state_q <= halt ? SQ_IDLE : SQ_GAP;
          end
          SQ_GAP: begin
            cs_q    <= idle_cs;
            state_q <= SQ_IDLE;
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign xfer_valid = (state_q == SQ_ISSUE);
  assign rx_we      = fin;
  assign rx_idx     = wptr_q;
  assign cs_out     = cs_q;

  p_offer_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_tx) && $stable(xfer_len));

  p_cs_during_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_BUSY) && !done_valid |=> $stable(cs_out));

  p_gap_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_GAP) |-> cs_out == $past(idle_cs));

endmodule

// File: rtl/spi_queue_seq.sv
module spi_queue_seq
  import spi_queue_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4,
  parameter int CS_W   = 4,
  parameter int LEN_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  input  logic [PTR_W+1:0]   cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [DATA_W-1:0]  xfer_tx,
  output logic [LEN_W-1:0]   xfer_len,
  input  logic               done_valid,
  input  logic [DATA_W-1:0]  done_rx,
  output logic [CS_W-1:0]    cs_out,
  output logic               irq
);
  localparam int CMD_W = CS_W + LEN_W + 1;

  logic [1:0]        rgn;
  logic [PTR_W-1:0]  idx;
  logic              reg_wr, reg_rd;
  logic              en, wrap, newp_wr, flag, flag_set, en_clr, rx_we;
  logic [PTR_W-1:0]  new_ptr, end_ptr, done_ptr, seq_idx, rx_idx;
  logic [CS_W-1:0]   idle_cs;
  logic [DATA_W-1:0] reg_rdata, cpu_tx, cpu_rx, seq_tx;
  logic [CMD_W-1:0]  cpu_cmd, seq_cmd;

  assign rgn    = cpu_addr[PTR_W+1:PTR_W];
  assign idx    = cpu_addr[PTR_W-1:0];
  assign reg_wr = cpu_wr && (rgn == RGN_REG);
  assign reg_rd = cpu_rd && (rgn == RGN_REG);

  spi_queue_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CS_W(CS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .off(idx),
    .wdata(cpu_wdata), .flag_set(flag_set), .en_clr(en_clr),
    .done_ptr(done_ptr), .en(en), .wrap(wrap), .new_ptr(new_ptr),
    .newp_wr(newp_wr), .end_ptr(end_ptr), .idle_cs(idle_cs),
    .flag(flag), .irq(irq), .rdata(reg_rdata)
  );

  spi_queue_ram #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CMD_W(CMD_W)) u_ram (
    .clk(clk),
    .tx_we(cpu_wr && (rgn == RGN_TX)),
    .cmd_we(cpu_wr && (rgn == RGN_CMD)),
    .cpu_idx(idx), .cpu_wdata(cpu_wdata),
    .cpu_tx(cpu_tx), .cpu_rx(cpu_rx), .cpu_cmd(cpu_cmd),
    .seq_idx(seq_idx), .seq_tx(seq_tx), .seq_cmd(seq_cmd),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(done_rx)
  );

  spi_queue_fsm #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CS_W(CS_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .new_ptr(new_ptr),
    .newp_wr(newp_wr), .end_ptr(end_ptr), .idle_cs(idle_cs),
    .seq_idx(seq_idx), .seq_tx(seq_tx), .seq_cmd(seq_cmd),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tx(xfer_tx),
    .xfer_len(xfer_len), .done_valid(done_valid), .rx_we(rx_we),
    .rx_idx(rx_idx), .done_ptr(done_ptr), .flag_set(flag_set),
    .en_clr(en_clr), .cs_out(cs_out)
  );

  always_comb begin
    unique case (rgn)
      RGN_REG: cpu_rdata = reg_rdata;
      RGN_TX:  cpu_rdata = cpu_tx;
      RGN_RX:  cpu_rdata = cpu_rx;
      default: cpu_rdata = DATA_W'(cpu_cmd);
    endcase
  end

  p_end_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag);

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr && !(reg_wr && idx == PTR_W'(OFF_CTRL)) |=> !en && !xfer_valid);

endmodule

// File: tb/spi_queue_seq_test.sv
module spi_queue_seq_test;
  localparam int DW = 16, PW = 4, CW = 4, LW = 4, LAT = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cpu_wr, cpu_rd, xfer_ready, done_valid, xfer_valid, irq;
  logic [PW+1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, xfer_tx, done_rx;
  logic [LW-1:0] xfer_len;
  logic [CW-1:0] cs_out;

  spi_queue_seq uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tx(xfer_tx),
    .xfer_len(xfer_len), .done_valid(done_valid), .done_rx(done_rx),
    .cs_out(cs_out), .irq(irq)
  );

  int checks = 0, fails = 0;
  int nlog, cs_bad, stab_bad, rdy_wait;
  logic [DW-1:0] tx_log [64];
  logic          gap_log [64];
  logic [CW-1:0] cs_log [64];
  logic [CW-1:0] cs_m [16];
  logic [DW-1:0] tx_m [16];
  logic [CW-1:0] idle_v;
  bit gap_seen;

  // rows: start pointer, last pointer, ready delay
  localparam logic [11:0] VEC [5] = '{12'h030, 12'h551, 12'hDF2, 12'h793, 12'h001};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [PW+1:0] a, input logic [DW-1:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [PW+1:0] a, output logic [DW-1:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  function automatic logic [PW+1:0] ra(input int r, input int i);
    return {r[1:0], i[3:0]};
  endfunction

  task automatic set_cmd(input int i, input logic [3:0] cs, input bit cont);
    cs_m[i] = cs;
    wr(ra(3, i), {7'b0, cont, i[3:0], cs});
  endtask

  task automatic load_tx(input int seed);
    for (int i = 0; i < 16; i++) begin
      tx_m[i] = {4'h8, seed[3:0], 4'h0, i[3:0]};
      wr(ra(1, i), tx_m[i]);
    end
  endtask

  task automatic wait_halt();
    logic [DW-1:0] d;
    int g = 0;
    do begin rd(ra(0, 0), d); g++; end while (d[0] && g < 3000);
  endtask

  task automatic clear_flag();
    logic [DW-1:0] d;
    rd(ra(0, 4), d);
    wr(ra(0, 4), 16'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // shift engine model
  initial begin
    int ph, cnt, w;
    logic [DW-1:0] first_tx, cur_tx;
    logic [CW-1:0] cur_cs;
    ph = 0; cnt = 0; w = 0; first_tx = '0; cur_tx = '0; cur_cs = '0;
    xfer_ready = 1'b0; done_valid = 1'b0; done_rx = '0;
    forever begin
      @(negedge clk);
      xfer_ready = 1'b0; done_valid = 1'b0;
      if (!rst_n) begin
        ph = 0; w = 0;
      end else if (ph == 0) begin
        if (xfer_valid) begin
          if (w == 0) first_tx = xfer_tx;
          else if (xfer_tx != first_tx) stab_bad++;
          if (w >= rdy_wait) begin
            xfer_ready = 1'b1; cur_tx = xfer_tx; cur_cs = cs_out;
            if (nlog < 64) begin
              tx_log[nlog] = xfer_tx; gap_log[nlog] = gap_seen; cs_log[nlog] = cs_out;
            end
            nlog++; gap_seen = 1'b0; ph = 1; cnt = LAT; w = 0;
          end else w++;
        end else if (cs_out == idle_v) gap_seen = 1'b1;
      end else begin
        if (cs_out != cur_cs) cs_bad++;
        cnt--;
        if (cnt == 0) begin
          done_valid = 1'b1; done_rx = cur_tx ^ 16'h5A5A; ph = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int s, e, n, k;
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    nlog = 0; cs_bad = 0; stab_bad = 0; rdy_wait = 0; idle_v = 4'hF; gap_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk(cs_out == 4'hF, "R14 cs_out", 32'(cs_out), 32'hF);
    chk(!xfer_valid && !irq, "R14 valid/irq", {30'b0, xfer_valid, irq}, 0);
    rd(ra(0, 0), d); chk(d == 0, "R14 control", 32'(d), 0);
    rd(ra(0, 3), d); chk(d == 0, "R14 finished ptr", 32'(d), 0);
    rd(ra(0, 5), d); chk(d == 16'hF, "R14 idle pattern", 32'(d), 32'hF);
    rd(ra(0, 4), d); chk(d == 0, "R14 flag", 32'(d), 0);

    // vector table: plain runs without wraparound
    for (int v = 0; v < 5; v++) begin
      s = int'(VEC[v][11:8]); e = int'(VEC[v][7:4]); rdy_wait = int'(VEC[v][3:0]);
      n = e - s + 1;
      load_tx(v + 1);
      for (int i = s; i <= e; i++) set_cmd(i, {1'b0, i[2:0]}, 1'b0);
      nlog = 0; cs_bad = 0; stab_bad = 0;
      wr(ra(0, 1), 16'(s)); wr(ra(0, 2), 16'(e)); wr(ra(0, 0), 16'h5);
      wait_halt();
      chk(nlog == n, "R9 transfer count", 32'(nlog), 32'(n));
      chk(tx_log[0] == tx_m[s], "R2 first entry", 32'(tx_log[0]), 32'(tx_m[s]));
      for (int j = 1; j < n; j++) begin
        chk(tx_log[j] == tx_m[s + j], "R3 order", 32'(tx_log[j]), 32'(tx_m[s + j]));
        chk(gap_log[j] == 1'b1, "R7 idle between", 32'(gap_log[j]), 1);
      end
      rd(ra(2, s), d); chk(d == (tx_m[s] ^ 16'h5A5A), "R2 rx stored", 32'(d), 32'(tx_m[s] ^ 16'h5A5A));
      rd(ra(2, e), d); chk(d == (tx_m[e] ^ 16'h5A5A), "R3 rx stored", 32'(d), 32'(tx_m[e] ^ 16'h5A5A));
      rd(ra(0, 3), d); chk(d == 16'(e), "R3 finished ptr", 32'(d), 32'(e));
      chk(irq == 1'b1, "R12 irq", 32'(irq), 1);
      chk(cs_out == 4'hF && !xfer_valid, "R9 halted idle", 32'(cs_out), 32'hF);
      chk(cs_bad == 0, "R6 cs steady", 32'(cs_bad), 0);
      chk(stab_bad == 0, "R13 offer hold", 32'(stab_bad), 0);
      rd(ra(0, 4), d); chk(d[0] == 1'b1, "R8 flag set", 32'(d), 1);
      wr(ra(0, 4), 16'h0);
      rd(ra(0, 4), d); chk(d[0] == 1'b0 && !irq, "R11 read-then-zero clears", 32'(d), 0);
    end
    rdy_wait = 1;

    // R11 clear protocol corners
    wr(ra(0, 1), 16'h0); wr(ra(0, 2), 16'h0); wr(ra(0, 0), 16'h1);
    wait_halt();
    wr(ra(0, 4), 16'h0);
    @(negedge clk); #1 cpu_addr = ra(0, 4); #1 d = cpu_rdata;
    chk(d[0] == 1'b1, "R11 zero write without read", 32'(d), 1);
    rd(ra(0, 4), d); wr(ra(0, 4), 16'h1); wr(ra(0, 4), 16'h0);
    @(negedge clk); #1 cpu_addr = ra(0, 4); #1 d = cpu_rdata;
    chk(d[0] == 1'b1, "R11 write cancels pending read", 32'(d), 1);
    clear_flag();
    @(negedge clk); #1 cpu_addr = ra(0, 4); #1 d = cpu_rdata;
    chk(d[0] == 1'b0, "R11 clear", 32'(d), 0);

    // R5 continue with the same pattern
    set_cmd(0, 4'h3, 1'b1); set_cmd(1, 4'h3, 1'b1); set_cmd(2, 4'h3, 1'b0);
    nlog = 0; cs_bad = 0;
    wr(ra(0, 1), 16'h0); wr(ra(0, 2), 16'h2); wr(ra(0, 0), 16'h1);
    wait_halt();
    chk(nlog == 3, "R5 count", 32'(nlog), 3);
    chk(gap_log[1] == 0 && gap_log[2] == 0, "R5 no idle gap", {30'b0, gap_log[1], gap_log[2]}, 0);
    chk(cs_log[1] == 4'h3 && cs_log[2] == 4'h3 && cs_bad == 0, "R5 pattern held", 32'(cs_log[2]), 3);
    clear_flag();

    // R6 continue with a changing pattern
    set_cmd(4, 4'h1, 1'b1); set_cmd(5, 4'h2, 1'b1); set_cmd(6, 4'h5, 1'b0);
    nlog = 0; cs_bad = 0;
    wr(ra(0, 1), 16'h4); wr(ra(0, 2), 16'h6); wr(ra(0, 0), 16'h1);
    wait_halt();
    chk(cs_log[0] == 4'h1 && cs_log[1] == 4'h2 && cs_log[2] == 4'h5, "R6 switch at start",
        {20'b0, cs_log[0], cs_log[1], cs_log[2]}, 32'h125);
    chk(gap_log[1] == 0 && gap_log[2] == 0 && cs_bad == 0, "R6 no gap", 32'(cs_bad), 0);
    chk(cs_out == 4'hF, "R9 idle after last", 32'(cs_out), 32'hF);
    clear_flag();

    // R10 and R12 wraparound with buffered interrupt enable
    for (int i = 0; i < 16; i++) set_cmd(i, 4'h6, 1'b0);
    nlog = 0;
    wr(ra(0, 1), 16'h0); wr(ra(0, 2), 16'h1); wr(ra(0, 0), 16'h7);
    while (nlog < 5) @(negedge clk);
    chk(tx_log[2] == tx_m[0] && tx_log[3] == tx_m[1] && tx_log[4] == tx_m[0], "R10 wraps to 0",
        32'(tx_log[2]), 32'(tx_m[0]));
    chk(irq == 1'b1, "R12 irq while wrapping", 32'(irq), 1);
    wr(ra(0, 0), 16'h3);
    chk(irq == 1'b1, "R12 disable keeps request", 32'(irq), 1);
    clear_flag();
    k = nlog;
    while (nlog < k + 3) @(negedge clk);
    rd(ra(0, 4), d);
    chk(d[0] == 1'b1, "R8 flag set again under wrap", 32'(d), 1);
    chk(irq == 1'b0, "R12 later request masked", 32'(irq), 0);
    wr(ra(0, 0), 16'h0);
    repeat (40) @(negedge clk);
    k = nlog;
    repeat (30) @(negedge clk);
    chk(nlog == k && !xfer_valid && cs_out == 4'hF, "R10 stops when disabled", 32'(nlog), 32'(k));
    clear_flag();

    // R4 start pointer override mid-run, R7 programmed idle pattern
    idle_v = 4'hE; wr(ra(0, 5), 16'hE);
    rdy_wait = 0; nlog = 0;
    wr(ra(0, 1), 16'h0); wr(ra(0, 2), 16'hF); wr(ra(0, 0), 16'h1);
    while (nlog < 1) @(negedge clk);
    wr(ra(0, 1), 16'hA);
    wait_halt();
    chk(tx_log[1] == tx_m[10], "R4 override index", 32'(tx_log[1]), 32'(tx_m[10]));
    chk(nlog == 7, "R4 run length", 32'(nlog), 7);
    chk(gap_log[1] == 1'b1 && cs_out == 4'hE, "R7 programmed idle", 32'(cs_out), 32'hE);
    rd(ra(0, 3), d); chk(d == 16'hF, "R3 finished ptr at 15", 32'(d), 32'hF);
    rd(ra(2, 15), d); chk(d == (tx_m[15] ^ 16'h5A5A), "R3 rx at 15", 32'(d), 32'(tx_m[15] ^ 16'h5A5A));
    rd(ra(3, 5), d); chk(d == {7'b0, 1'b0, 4'h5, 4'h6}, "R1 command readback", 32'(d), 32'h056);

    finish_run();
  end
endmodule